// File: doc/BRIEF.md
# Dual-Channel Phase-Selectable PWM Generator

This block turns two duty-cycle command words into two digital high-side drive requests for a pair of synchronous buck stages. A single free-running carrier counter sets the switching period. The second channel sees a copy of that carrier, shifted back by zero, a quarter or a half of the period. The shift is chosen from two static inputs. One says whether the second stage tracks the first, as in a memory supply. The other says whether the input rail is a resistor-strapped 5 V rail or a battery. Each channel latches its command only when its own carrier wraps. A command change in mid-period therefore cannot cut a pulse short or add a stray one.

Each channel has a maximum-duty clamp. It engages when that channel's severe-excursion flag has been held across two consecutive carrier wraps. A per-channel disable input replaces the clamp with a fixed 87 % ceiling. Two combinational flags report whether light-load hysteretic operation may be used. Soft-start blocks it on both channels. Tracking mode blocks it on the second channel.

Top module: `dual_phase_pwm`

## Requirements
- R1: Reset is synchronous and active high. While it is applied, and from its release until each channel's first carrier wrap, both drive requests are low.
- R2: In every carrier period a channel's drive request is high for the first D counts and low for the remaining counts. D is the command latched at that period's start, after limiting. Commands run from 0 to PERIOD-1, and 0 gives no pulse.
- R3: A command change in mid-period has no effect until that channel's next carrier wrap.
- R4: With track_mode=1 and src_5v=0, channel 2's carrier is in phase with channel 1's carrier.
- R5: With track_mode=1 and src_5v=1, channel 2's carrier lags channel 1's carrier by PERIOD/4 counts.
- R6: With track_mode=0, channel 2's carrier lags by PERIOD/2 counts, whatever the value of src_5v.
- R7: If a channel's severe flag is high without a break across two of that channel's wraps, the duty latched at the second wrap, and at every later wrap while the flag stays high, is limited to CLAMP_DUTY. When the flag drops, the next wrap latches the command without this limit.
- R8: While a channel's clamp_dis input is high, the duty latched at a wrap is limited to floor(PERIOD*87/100) counts, and the severe flag has no effect on it.
- R9: hyst_ok1 is high exactly when soft_start is low.
- R10: hyst_ok2 is low whenever soft_start or track_mode is high, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| track_mode | input | 1 | 1 = channel 2 tracks channel 1 (memory-supply mode) |
| src_5v | input | 1 | 1 = resistor-strapped 5 V input rail, 0 = battery rail |
| soft_start | input | 1 | High while soft-start is in progress |
| duty1 | input | CW | Channel 1 duty command in carrier counts |
| duty2 | input | CW | Channel 2 duty command in carrier counts |
| severe1 | input | 1 | Channel 1 severe output excursion flag |
| severe2 | input | 1 | Channel 2 severe output excursion flag |
| clamp_dis1 | input | 1 | Channel 1 clamp bypass (fixed 87 % ceiling) |
| clamp_dis2 | input | 1 | Channel 2 clamp bypass (fixed 87 % ceiling) |
| hs_req1 | output | 1 | Channel 1 high-side drive request |
| hs_req2 | output | 1 | Channel 2 high-side drive request |
| hyst_ok1 | output | 1 | Channel 1 may use hysteretic mode |
| hyst_ok2 | output | 1 | Channel 2 may use hysteretic mode |

## Verification
A command, a clamp decision or a disable takes effect on the clock edge that moves a channel's carrier from PERIOD-1 to 0. The drive request reflects it from that same edge, so a full period is due exactly one edge after the wrap and PERIOD cycles long. The hysteretic flags settle within the cycle their inputs change. The scoreboard computes the expected pulse width at each channel's wrap, from the inputs the design sees on that edge. The monitor samples 1 ns after each rising edge, splits the output into periods at the requirement's phase offset, and compares the pulse length and shape once the next wrap closes the period. Mode changes are made only under reset, so no period straddles a change of phase.

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm #(
  parameter int PERIOD = 256,
  parameter int CLAMP_DUTY = (PERIOD * 5) / 8,
  parameter int DIS_PCT = 87,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          track_mode,
  input  logic          src_5v,
  input  logic          soft_start,
  input  logic [CW-1:0] duty1,
  input  logic [CW-1:0] duty2,
  input  logic          severe1,
  input  logic          severe2,
  input  logic          clamp_dis1,
  input  logic          clamp_dis2,
  output logic          hs_req1,
  output logic          hs_req2,
  output logic          hyst_ok1,
  output logic          hyst_ok2
);
  localparam int LW = CW + 1;
  localparam int DIS_LIM = (PERIOD * DIS_PCT) / 100;
  localparam logic [LW-1:0] P_L = LW'(PERIOD);

  logic [CW-1:0] cnt1, cnt2, off;
  logic [LW-1:0] sum;
  logic [CW-1:0] cnt [2];
  logic [CW-1:0] cmd [2];
  logic [1:0]    sev, dis, hs;

  always_comb begin
    if (!track_mode)  off = CW'(PERIOD / 2);
    else if (src_5v)  off = CW'(PERIOD / 4);
    else              off = '0;
  end

  assign sum  = {1'b0, cnt1} + P_L - {1'b0, off};
  assign cnt2 = (sum >= P_L) ? CW'(sum - P_L) : sum[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst)                            cnt1 <= '0;
    else if (cnt1 == CW'(PERIOD - 1))   cnt1 <= '0;
    else                                cnt1 <= cnt1 + 1'b1;
  end

  assign cnt[0] = cnt1;
  assign cnt[1] = cnt2;
  assign cmd[0] = duty1;
  assign cmd[1] = duty2;
  assign sev    = {severe2, severe1};
  assign dis    = {clamp_dis2, clamp_dis1};

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic          wrap;
    logic [1:0]    sc, sc_nxt;
    logic [LW-1:0] lim;
    logic [CW-1:0] lat;

    assign wrap = (cnt[ch] == CW'(PERIOD - 1));

    always_comb begin
      if (!sev[ch])                   sc_nxt = 2'd0;
      else if (wrap && sc != 2'd2)    sc_nxt = sc + 2'd1;
      else                            sc_nxt = sc;
      if (dis[ch])                    lim = LW'(DIS_LIM);
      else if (sc_nxt == 2'd2)        lim = LW'(CLAMP_DUTY);
      else                            lim = P_L;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        sc  <= 2'd0;
        lat <= '0;
      end else begin
        sc <= sc_nxt;
        if (wrap) lat <= ({1'b0, cmd[ch]} < lim) ? cmd[ch] : lim[CW-1:0];
      end
    end

    assign hs[ch] = (cnt[ch] < lat);
  end

  assign hs_req1  = hs[0];
  assign hs_req2  = hs[1];
  assign hyst_ok1 = !soft_start;
  assign hyst_ok2 = !soft_start && !track_mode;
endmodule

module dual_phase_pwm_chk #(
  parameter int PERIOD = 256,
  parameter int DIS_PCT = 87,
  localparam int CW = $clog2(PERIOD)
) (
  input logic          clk,
  input logic          rst,
  input logic          track_mode,
  input logic          src_5v,
  input logic          clamp_dis1,
  input logic          hs_req1,
  input logic          hs_req2,
  input logic          hyst_ok2,
  input logic [CW-1:0] cnt1,
  input logic [CW-1:0] cnt2,
  input logic [CW-1:0] lat1
);
  localparam int DIS_LIM = (PERIOD * DIS_PCT) / 100;
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    // R1
    if (rst_q) begin
      reset_low_chk: assert (!hs_req1 && !hs_req2) else $error("drive request high after reset");
    end
  end

  // R2
  rise_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_req1) |-> cnt1 == '0);

  // R3
  lat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt1 != '0) |-> $stable(lat1));

  // R4
  in_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (track_mode && !src_5v) |-> cnt2 == cnt1);

  // R6
  half_shift_chk: assert property (@(posedge clk) disable iff (rst)
    !track_mode |-> int'(cnt2) == (int'(cnt1) + PERIOD / 2) % PERIOD);

  // R8
  dis_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt1 == '0 && $past(clamp_dis1)) |-> int'(lat1) <= DIS_LIM);

  // R10
  hyst_track_chk: assert property (@(posedge clk) disable iff (rst)
    track_mode |-> !hyst_ok2);
endmodule

bind dual_phase_pwm dual_phase_pwm_chk #(.PERIOD(PERIOD), .DIS_PCT(DIS_PCT)) chk_i (
  .clk(clk), .rst(rst), .track_mode(track_mode), .src_5v(src_5v),
  .clamp_dis1(clamp_dis1), .hs_req1(hs_req1), .hs_req2(hs_req2),
  .hyst_ok2(hyst_ok2), .cnt1(cnt1), .cnt2(cnt2), .lat1(g_ch[0].lat)
);

// File: tb/dual_phase_pwm_tb_top.sv
module dual_phase_pwm_tb_top;
  localparam int P   = 16;
  localparam int CL  = (P * 5) / 8;
  localparam int DL  = (P * 87) / 100;
  localparam int CW  = $clog2(P);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic track = 1'b0, src = 1'b0, ss = 1'b0;
  logic [CW-1:0] d1 = '0, d2 = '0;
  logic [1:0] sev = '0, dis = '0;
  logic hs1, hs2, h1, h2;

  int n_run = 0, n_fail = 0;
  string tag = "R1";
  int q0[$], q1[$];

  always #2 clk = ~clk;

  dual_phase_pwm #(.PERIOD(P)) dut_i (
    .clk(clk), .rst(rst), .track_mode(track), .src_5v(src), .soft_start(ss),
    .duty1(d1), .duty2(d2), .severe1(sev[0]), .severe2(sev[1]),
    .clamp_dis1(dis[0]), .clamp_dis2(dis[1]),
    .hs_req1(hs1), .hs_req2(hs2), .hyst_ok1(h1), .hyst_ok2(h2)
  );

  task automatic check(input bit ok, input string t, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  function automatic int phase_of(input int k, input int ch);
    int off;
    off = (ch == 0) ? 0 : (!track ? P / 2 : (src ? P / 4 : 0));
    return ((k - off) % P + P) % P;
  endfunction

  // driver side: expected pulse width per period, pushed at each wrap
  int gk = 0;
  int gs [2] = '{0, 0};
  always @(posedge clk) begin
    #1;
    if (rst) begin
      gk = 0; gs = '{0, 0}; q0.delete(); q1.delete();
    end else begin
      gk++;
      for (int ch = 0; ch < 2; ch++) begin
        int c, lim, cmdv, e;
        c = phase_of(gk, ch);
        if (!sev[ch]) gs[ch] = 0;
        if (c == 0) begin
          if (sev[ch] && gs[ch] < 2) gs[ch]++;
          lim  = dis[ch] ? DL : (gs[ch] == 2 ? CL : P);
          cmdv = (ch == 0) ? int'(d1) : int'(d2);
          e    = (cmdv < lim) ? cmdv : lim;
          if (ch == 0) q0.push_back(e); else q1.push_back(e);
        end
      end
    end
  end

  // monitor: measure each period and compare with the scoreboard
  int mk = 0;
  bit act [2] = '{0, 0};
  bit sl [2]  = '{0, 0};
  bit bad [2] = '{0, 0};
  int hi [2]  = '{0, 0};
  always @(posedge clk) begin
    #1;
    if (rst) begin
      mk = 0; act = '{0, 0};
    end else begin
      mk++;
      for (int ch = 0; ch < 2; ch++) begin
        int c, e, got;
        logic o;
        c = phase_of(mk, ch);
        o = (ch == 0) ? hs1 : hs2;
        if (c == 0) begin
          if (act[ch]) begin
            got = bad[ch] ? -1 : hi[ch];
            if (ch == 0 && q0.size() > 0) e = q0.pop_front();
            else if (ch == 1 && q1.size() > 0) e = q1.pop_front();
            else e = -2;
            check(got == e, $sformatf("%s ch%0d pulse", tag, ch + 1), got, e);
          end
          act[ch] = 1; hi[ch] = 0; sl[ch] = 0; bad[ch] = 0;
        end
        if (act[ch]) begin
          if (o) begin
            if (sl[ch]) bad[ch] = 1;
            hi[ch]++;
          end else sl[ch] = 1;
        end
      end
    end
  end

  task automatic do_reset(input logic tm, input logic s5);
    @(negedge clk);
    rst = 1'b1; track = tm; src = s5;
    repeat (3) @(negedge clk);
    check(!hs1 && !hs2, "R1 outputs in reset", int'(hs1) + int'(hs2), 0);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: no pulse before the first wrap even with a command present
    d1 = 4'd9; d2 = 4'd9; tag = "R1";
    do_reset(1'b0, 1'b0);
    run(2);
    check(!hs1, "R1 ch1 before first wrap", int'(hs1), 0);
    check(!hs2, "R1 ch2 before first wrap", int'(hs2), 0);
    tag = "R6"; run(80);

    d1 = 4'd7; d2 = 4'd2; tag = "R6";
    do_reset(1'b0, 1'b1); run(80);

    d1 = 4'd5; d2 = 4'd8; tag = "R4";
    do_reset(1'b1, 1'b0); run(96);

    d1 = 4'd3; d2 = 4'd12; tag = "R5";
    do_reset(1'b1, 1'b1); run(96);

    d1 = 4'd0; d2 = 4'd15; tag = "R2";
    do_reset(1'b1, 1'b0); run(64);

    tag = "R3";
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 12; i++) begin
      run(7);
      d1 = d1 + 4'd5; d2 = d2 + 4'd3;
    end
    run(32);

    d1 = 4'd15; d2 = 4'd15; tag = "R7";
    do_reset(1'b0, 1'b0); run(41);
    sev[0] = 1'b1;
    for (int i = 0; i < 5; i++) begin
      run(15); sev[1] = 1'b1; run(1); sev[1] = 1'b0;
    end
    sev[0] = 1'b0; run(48);

    tag = "R8";
    do_reset(1'b0, 1'b0);
    dis = 2'b11; sev = 2'b11; run(96);
    dis = 2'b00; sev = 2'b00; run(32);

    @(negedge clk); ss = 1'b1; track = 1'b1; @(negedge clk);
    check(h1 == 1'b0, "R9 soft-start ch1", int'(h1), 0);
    check(h2 == 1'b0, "R10 soft-start ch2", int'(h2), 0);
    @(negedge clk); ss = 1'b0; @(negedge clk);
    check(h1 == 1'b1, "R9 after soft-start ch1", int'(h1), 1);
    check(h2 == 1'b0, "R10 tracking ch2", int'(h2), 0);
    @(negedge clk); track = 1'b0; @(negedge clk);
    check(h2 == 1'b1, "R10 independent ch2", int'(h2), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule